// File: doc/BRIEF.md
# Parity-Augmented Self-Testable Logic Array

This block is a parameterized two-level logic array with `N_IN` inputs, `N_PROD` user product terms and `N_OUT` user outputs. The AND plane and OR plane connection maps are fixed at elaboration as flat bit-vector parameters. Each product term is the NOR of the bit lines it connects to. A bit line is either an input (true line) or its inverse (complement line). Each output is the OR of the product terms it connects to, so the pair forms a NOR-NOR sum of products.

To make the array testable with a function-independent test set, elaboration adds hidden parity structure:
- Parity product columns are added so that the total column count `M` is even. Each true and each complement bit line then carries an odd number of connections and an odd number of gaps.
- A parity output row is added so that every product column, the added ones included, drives an odd number of outputs.

Three extra controls support the test:
- A per-column disable vector can switch off any product term, the parity columns included.
- Two force inputs independently pull every true bit line low, or every complement bit line low.

The output vector is captured in a register, so results appear one clock after the inputs. A single crosspoint flip can be requested through parameters, so that a test procedure can be shown to catch it.

Top module: `pla_parity_core`

## Requirements
- R1: While `rst_n` is low, `pla_out` is all zeros, whatever the other inputs are.
- R2: With both force inputs low and all columns enabled, `pla_out[N_OUT-1:0]` equals the sum of products given by `AND_TRUE_MAP`, `AND_COMP_MAP` and `OR_MAP`. The value appears one clock after the inputs.
  - In `AND_TRUE_MAP`, bit `j*N_IN+i` connects true line i to product j.
  - `AND_COMP_MAP` uses the same layout for the complement lines.
  - In `OR_MAP`, bit `k*N_PROD+j` connects product j to output k.
- R3: A product column whose `term_off` bit is 1 has no effect on any output. Bit j of `term_off` controls column j, and user columns come before parity columns. With every bit set, the output is all zeros.
- R4: With both force inputs high and exactly one column enabled, `pla_out` has odd parity.
- R5: Hold `kill_comp` high, `kill_true` low and `pla_in` one-hot on bit i. Then step a single enabled column over all `M` columns. The XOR of the output parities over those `M` steps is 1.
- R6: Hold `kill_true` high, `kill_comp` low and `pla_in` all ones except bit i. Then step as in R5. The XOR of the output parities is 1.
- R7: With both force inputs high, the output does not depend on `pla_in`. Every enabled user product is then true.
- R8: If the `FAULT_*` parameters flip the crosspoint between true line 0 and product 0, the R5 fold for bit line 0 gives 0. The R4 parity is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pla_in | input | N_IN | Input vector |
| term_off | input | M | Per-column disable, 1 = column off |
| kill_true | input | 1 | Forces all true bit lines to 0 |
| kill_comp | input | 1 | Forces all complement bit lines to 0 |
| pla_out | output | N_OUT+1 | Registered user outputs plus the parity row in the top bit |

## Verification
The bench drives four pattern families:
- An input sweep with every column enabled, then with a partial disable pattern. These separate the sum-of-products function from disable leakage.
- Both lines forced with one column enabled at a time. This tells a good OR-plane column parity from a broken one, independent of the inputs.
- One true bit line live, or one complement bit line live, while a single column is stepped across the array. Folding the parities over the step exposes an AND-plane crosspoint that is wrong on that line.
- A second instance built with one flipped crosspoint. It shows that the fold flips only for the affected line.

// File: rtl/pla_parity_pkg.sv
package pla_parity_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_AND_TRUE = 2'd1,
        FLT_AND_COMP = 2'd2,
        FLT_OR       = 2'd3
    } fault_plane_e;

    // Parity columns needed so the total column count is even.
    function automatic int parity_cols(input int n_prod);
        return (n_prod % 2 == 1) ? 1 : 2;
    endfunction

endpackage

// File: rtl/pla_bitline_drive.sv
module pla_bitline_drive #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0] pla_in,
    input  logic            kill_true,
    input  logic            kill_comp,
    output logic [N_IN-1:0] bl_true,
    output logic [N_IN-1:0] bl_comp
);
    always_comb begin
        bl_true = kill_true ? '0 : pla_in;
        bl_comp = kill_comp ? '0 : ~pla_in;
    end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int               N_IN  = 4,
    parameter int               M     = 6,
    parameter logic [M*N_IN-1:0] T_MAP = '0,
    parameter logic [M*N_IN-1:0] C_MAP = '0
) (
    input  logic [N_IN-1:0] bl_true,
    input  logic [N_IN-1:0] bl_comp,
    input  logic [M-1:0]    term_off,
    output logic [M-1:0]    prod
);
    for (genvar j = 0; j < M; j++) begin : g_col
        localparam logic [N_IN-1:0] TJ = T_MAP[j*N_IN +: N_IN];
        localparam logic [N_IN-1:0] CJ = C_MAP[j*N_IN +: N_IN];
        logic pulled;
        always_comb begin
            pulled  = |((TJ & bl_true) | (CJ & bl_comp));
            prod[j] = ~term_off[j] & ~pulled;
        end
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int              M     = 6,
    parameter int              P1    = 4,
    parameter logic [P1*M-1:0] O_MAP = '0
) (
    input  logic [M-1:0]  prod,
    output logic [P1-1:0] sums
);
    for (genvar k = 0; k < P1; k++) begin : g_row
        localparam logic [M-1:0] OK = O_MAP[k*M +: M];
        always_comb sums[k] = |(OK & prod);
    end
endmodule

// File: rtl/pla_parity_core.sv
module pla_parity_core #(
    parameter int N_IN   = 4,
    parameter int N_PROD = 5,
    parameter int N_OUT  = 3,
    parameter logic [N_PROD*N_IN-1:0]  AND_TRUE_MAP = 20'h90241,
    parameter logic [N_PROD*N_IN-1:0]  AND_COMP_MAP = 20'h06810,
    parameter logic [N_OUT*N_PROD-1:0] OR_MAP       = 15'h4A93,
    parameter pla_parity_pkg::fault_plane_e FAULT_PLANE = pla_parity_pkg::FLT_NONE,
    parameter int FAULT_ROW = 0,
    parameter int FAULT_COL = 0,
    localparam int M  = N_PROD + pla_parity_pkg::parity_cols(N_PROD),
    localparam int P1 = N_OUT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N_IN-1:0] pla_in,
    input  logic [M-1:0]    term_off,
    input  logic            kill_true,
    input  logic            kill_comp,
    output logic [P1-1:0]   pla_out
);
    import pla_parity_pkg::*;

    localparam int AW = M * N_IN;
    localparam int OW = P1 * M;

    // AND plane: copy user columns, then add parity columns so each bit
    // line ends with an odd connection count (the second extra stays empty).
    function automatic logic [AW-1:0] grow_and(input logic [N_PROD*N_IN-1:0] src);
        logic [AW-1:0] r;
        logic          par;
        r = '0;
        for (int i = 0; i < N_IN; i++) begin
            par = 1'b0;
            for (int j = 0; j < N_PROD; j++) begin
                r[j*N_IN+i] = src[j*N_IN+i];
                par         = par ^ src[j*N_IN+i];
            end
            r[N_PROD*N_IN+i] = ~par;
        end
        return r;
    endfunction

    // OR plane: copy user rows, then the parity row makes each column odd.
    function automatic logic [OW-1:0] grow_or(input logic [N_OUT*N_PROD-1:0] src);
        logic [OW-1:0] r;
        logic          par;
        r = '0;
        for (int j = 0; j < M; j++) begin
            par = 1'b0;
            for (int k = 0; k < N_OUT; k++) begin
                if (j < N_PROD) begin
                    r[k*M+j] = src[k*N_PROD+j];
                    par      = par ^ src[k*N_PROD+j];
                end
            end
            r[N_OUT*M+j] = ~par;
        end
        return r;
    endfunction

    localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [OW-1:0] ONE_O = {{(OW-1){1'b0}}, 1'b1};

    localparam logic [AW-1:0] FLIP_T = (FAULT_PLANE == FLT_AND_TRUE)
                                     ? (ONE_A << (FAULT_ROW*N_IN + FAULT_COL)) : '0;
    localparam logic [AW-1:0] FLIP_C = (FAULT_PLANE == FLT_AND_COMP)
                                     ? (ONE_A << (FAULT_ROW*N_IN + FAULT_COL)) : '0;
    localparam logic [OW-1:0] FLIP_O = (FAULT_PLANE == FLT_OR)
                                     ? (ONE_O << (FAULT_ROW*M + FAULT_COL)) : '0;

    localparam logic [AW-1:0] T_FULL = grow_and(AND_TRUE_MAP) ^ FLIP_T;
    localparam logic [AW-1:0] C_FULL = grow_and(AND_COMP_MAP) ^ FLIP_C;
    localparam logic [OW-1:0] O_FULL = grow_or(OR_MAP) ^ FLIP_O;

    logic [N_IN-1:0] bl_true, bl_comp;
    logic [M-1:0]    prod;
    logic [P1-1:0]   sums;

    pla_bitline_drive #(.N_IN(N_IN)) drive_i (
        .pla_in(pla_in), .kill_true(kill_true), .kill_comp(kill_comp),
        .bl_true(bl_true), .bl_comp(bl_comp)
    );

    pla_and_plane #(.N_IN(N_IN), .M(M), .T_MAP(T_FULL), .C_MAP(C_FULL)) and_i (
        .bl_true(bl_true), .bl_comp(bl_comp), .term_off(term_off), .prod(prod)
    );

    pla_or_plane #(.M(M), .P1(P1), .O_MAP(O_FULL)) or_i (
        .prod(prod), .sums(sums)
    );

    typedef struct packed {
        logic [P1-1:0] out;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = sums;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pla_out = st_q.out;

endmodule

// File: rtl/pla_parity_core_chk.sv
module pla_parity_core_chk #(
    parameter int N_IN = 4,
    parameter int M    = 6,
    parameter int P1   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] pla_in,
    input logic [M-1:0]    term_off,
    input logic            kill_true,
    input logic            kill_comp,
    input logic [P1-1:0]   pla_out
);
    logic [1:0] live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            live_q <= 2'd0;
        else if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    // R1: output held clear while reset is low
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> pla_out == '0);

    // R3: every column disabled gives an empty output
    assert_all_off_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0) && $past(&term_off) |-> pla_out == '0);

    // R4: single live column with all bit lines forced gives odd parity
    assert_single_col_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0) && $past(kill_true && kill_comp && ($countones(~term_off) == 1))
        |-> (^pla_out) == 1'b1);

    // R7: with both lines forced and the disables steady, input changes are invisible
    assert_forced_input_blind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3) && $past(kill_true && kill_comp) && $past(kill_true && kill_comp, 2)
        && ($past(term_off) == $past(term_off, 2)) |-> $stable(pla_out));

endmodule

bind pla_parity_core pla_parity_core_chk #(.N_IN(N_IN), .M(M), .P1(P1)) chk_i (
    .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .term_off(term_off),
    .kill_true(kill_true), .kill_comp(kill_comp), .pla_out(pla_out)
);

// File: tb/pla_parity_core_tb_top.sv
module pla_parity_core_tb_top;
    localparam int N_IN   = 4;
    localparam int N_PROD = 5;
    localparam int N_OUT  = 3;
    localparam int M      = N_PROD + ((N_PROD % 2 == 1) ? 1 : 2);
    localparam int P1     = N_OUT + 1;
    localparam logic [N_PROD*N_IN-1:0]  TMAP = 20'h90241;
    localparam logic [N_PROD*N_IN-1:0]  CMAP = 20'h06810;
    localparam logic [N_OUT*N_PROD-1:0] OMAP = 15'h4A93;

    localparam int K_EXACT = 0, K_PAR = 1, K_FOLD = 2, K_FOLD_END = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0] pla_in = '0;
    logic [M-1:0]    term_off = '0;
    logic            kill_true = 1'b0, kill_comp = 1'b0;
    logic [P1-1:0]   y_m, y_f;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pla_parity_core #(.N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT),
        .AND_TRUE_MAP(TMAP), .AND_COMP_MAP(CMAP), .OR_MAP(OMAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .term_off(term_off),
        .kill_true(kill_true), .kill_comp(kill_comp), .pla_out(y_m));

    // Same array with the crosspoint (true line 0, product 0) flipped.
    pla_parity_core #(.N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT),
        .AND_TRUE_MAP(TMAP), .AND_COMP_MAP(CMAP), .OR_MAP(OMAP),
        .FAULT_PLANE(pla_parity_pkg::FLT_AND_TRUE), .FAULT_ROW(0), .FAULT_COL(0)) dut_f (
        .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .term_off(term_off),
        .kill_true(kill_true), .kill_comp(kill_comp), .pla_out(y_f));

    typedef struct {
        int            due;
        int            kind;
        logic [P1-1:0] exp;
        logic [P1-1:0] msk;
        bit            faulty;
        string         tag;
    } item_t;

    item_t sb[$];
    logic  fold_m = 1'b0, fold_f = 1'b0;

    function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x, input logic kt,
                                               input logic kc, input logic [M-1:0] off);
        logic [N_IN-1:0] bt, bc;
        logic [N_OUT-1:0] r;
        logic pj;
        bt = kt ? '0 : x;
        bc = kc ? '0 : ~x;
        r  = '0;
        for (int j = 0; j < N_PROD; j++) begin
            pj = ~off[j] & ~|((TMAP[j*N_IN +: N_IN] & bt) | (CMAP[j*N_IN +: N_IN] & bc));
            for (int k = 0; k < N_OUT; k++)
                if (pj && OMAP[k*N_PROD+j]) r[k] = 1'b1;
        end
        return r;
    endfunction

    task automatic send(input logic [N_IN-1:0] x, input logic kt, input logic kc,
                        input logic [M-1:0] off, input int kind, input logic [P1-1:0] exp,
                        input logic [P1-1:0] msk, input bit faulty, input string tag);
        item_t it;
        @(negedge clk);
        pla_in = x; kill_true = kt; kill_comp = kc; term_off = off;
        it.due = cyc + 1; it.kind = kind; it.exp = exp; it.msk = msk;
        it.faulty = faulty; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cmp(input string tag, input logic [P1-1:0] act, input logic [P1-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: pops items whose result is due this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic [P1-1:0] y;
            logic par;
            it = sb.pop_front();
            y = it.faulty ? y_f : y_m;
            par = ^y;
            case (it.kind)
                K_EXACT: cmp(it.tag, y & it.msk, it.exp & it.msk);
                K_PAR:   cmp(it.tag, {{(P1-1){1'b0}}, par}, it.exp);
                default: begin
                    if (it.faulty) fold_f = fold_f ^ par;
                    else           fold_m = fold_m ^ par;
                    if (it.kind == K_FOLD_END) begin
                        cmp(it.tag, {{(P1-1){1'b0}}, (it.faulty ? fold_f : fold_m)}, it.exp);
                        if (it.faulty) fold_f = 1'b0; else fold_m = 1'b0;
                    end
                end
            endcase
        end
    end

    localparam logic [P1-1:0] LOWM = {1'b0, {N_OUT{1'b1}}};
    localparam logic [P1-1:0] ONE  = {{(P1-1){1'b0}}, 1'b1};

    // Step one enabled column over the whole array on both instances.
    task automatic sweep(input logic [N_IN-1:0] x, input logic kt, input logic kc,
                         input logic exp_m, input logic exp_f, input string tag);
        for (int j = 0; j < M; j++) begin
            logic [M-1:0] off;
            off = ~({{(M-1){1'b0}}, 1'b1} << j);
            send(x, kt, kc, off, (j == M-1) ? K_FOLD_END : K_FOLD,
                 {{(P1-1){1'b0}}, exp_m}, '1, 1'b0, tag);
            send(x, kt, kc, off, (j == M-1) ? K_FOLD_END : K_FOLD,
                 {{(P1-1){1'b0}}, exp_f}, '1, 1'b1, tag);
        end
    endtask

    initial begin
        // R1: reset dominates live inputs
        pla_in = 4'h5;
        repeat (3) @(negedge clk);
        cmp("R1 reset clear", y_m, '0);
        cmp("R1 reset clear faulty", y_f, '0);
        rst_n = 1'b1;

        // R2: normal function, all columns enabled, every input value
        for (int v = 0; v < (1 << N_IN); v++)
            send(v[N_IN-1:0], 1'b0, 1'b0, '0, K_EXACT,
                 {1'b0, model(v[N_IN-1:0], 1'b0, 1'b0, '0)}, LOWM, 1'b0, "R2 sop");

        // R3: partial disable pattern and full disable
        for (int v = 0; v < (1 << N_IN); v += 3)
            send(v[N_IN-1:0], 1'b0, 1'b0, 6'b010101, K_EXACT,
                 {1'b0, model(v[N_IN-1:0], 1'b0, 1'b0, 6'b010101)}, LOWM, 1'b0, "R3 partial off");
        for (int v = 0; v < 4; v++)
            send(v[N_IN-1:0] ^ 4'hA, v[0], v[1], '1, K_EXACT, '0, '1, 1'b0, "R3 all off");

        // R4: single column, both lines forced, both instances
        for (int j = 0; j < M; j++) begin
            send(4'h3, 1'b1, 1'b1, ~({{(M-1){1'b0}}, 1'b1} << j), K_PAR, ONE, '1, 1'b0, "R4 column parity");
            send(4'h3, 1'b1, 1'b1, ~({{(M-1){1'b0}}, 1'b1} << j), K_PAR, ONE, '1, 1'b1, "R8 column parity kept");
        end

        // R7: both lines forced, inputs vary
        for (int v = 0; v < (1 << N_IN); v += 5)
            send(v[N_IN-1:0], 1'b1, 1'b1, 6'b000100, K_EXACT,
                 {1'b0, model(4'h0, 1'b1, 1'b1, 6'b000100)}, LOWM, 1'b0, "R7 input ignored");

        // R5 / R8: true bit line folds
        for (int i = 0; i < N_IN; i++)
            sweep(4'h1 << i, 1'b0, 1'b1, 1'b1, (i == 0) ? 1'b0 : 1'b1,
                  (i == 0) ? "R5 R8 true line fold" : "R5 true line fold");

        // R6: complement bit line folds
        for (int i = 0; i < N_IN; i++)
            sweep(~(4'h1 << i), 1'b1, 1'b0, 1'b1, 1'b1, "R6 comp line fold");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule